// File: doc/BRIEF.md
# Monochrome Composite Raster Generator

This block builds a black-and-white raster for a 50 Hz, non-interlaced, PAL-style composite display. All timing runs from one pixel clock. A horizontal counter spans one 64 us scan line of 400 clocks. A vertical counter spans 312 lines per frame. Fixed compare points on the two counters define the sync pulses, the borders and the active picture.

Inside the active picture the block reads one byte of display memory for every eight pixels. It loads each byte into a shift register and sends the bits out most significant first. The display memory is outside the block. The memory address starts at a frame base and moves forward by one line of bytes for each active line.

The output is a 2-bit level code that carries sync, black and white on one composite signal. An external resistor ladder turns the code into roughly 0 V, 0.3 V or 1 V. No colour burst is generated. The block also gives a memory arbiter an active-window flag and a strobe that marks each shift-register load, so the arbiter can place processor accesses between video fetches. Every limit is a parameter, so an NTSC-style timing can reuse the same logic.

Top module: `mono_video_gen`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, the block is at line 0, count 0. In that state rd_en, load_stb and disp_active are 0 and vid_level is BLACK (2'b01). The async reset is released through a two-stage synchronizer, so counting starts on the third rising edge after rst_n goes high.
- R2: The horizontal count runs from 0 to H_TOTAL-1 and then wraps. A scan line is therefore exactly H_TOTAL clocks long.
- R3: On lines that are not vertical-sync lines, vid_level is SYNC (2'b00) for horizontal counts 0 to HSYNC_W-1, and for no other count.
- R4: On lines 0 to VSYNC_LINES-1 the sync polarity is inverted. vid_level is SYNC for horizontal counts HSYNC_W and above, and BLACK below HSYNC_W.
- R5: A frame is V_TOTAL lines long. The vertical-sync lines and the fetch sequence come back in every frame at the same positions.
- R6: disp_active is 1 exactly when the horizontal count is in [H_ACT_START, H_ACT_END) and the line is in [V_ACT_START, V_ACT_START+V_ACT_LINES).
- R7: When the block is neither in sync nor in the active window, vid_level is BLACK (2'b01).
- R8: On active lines rd_en pulses once for each byte, at horizontal counts H_ACT_START-2+8k for k = 0 to (H_ACT_END-H_ACT_START)/8-1. The address is FRAME_BASE + (line-V_ACT_START)*BPL + k, where BPL = (H_ACT_END-H_ACT_START)/8. rd_en is never high on other lines or counts.
- R9: rd_data is taken in the cycle after rd_en, which is one-cycle read latency. load_stb is 1 in exactly that cycle.
- R10: The pixel at horizontal count H_ACT_START+8k+j shows bit 7-j of byte k. A 1 bit gives WHITE (2'b10) and a 0 bit gives BLACK. The code 2'b11 never appears.
- R11: The first fetch of each frame, including the first frame after any reset, reads address FRAME_BASE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_data | input | 8 | Display byte returned one cycle after rd_en |
| rd_addr | output | AW | Display memory byte address |
| rd_en | output | 1 | Display memory read strobe |
| vid_level | output | 2 | Composite level code: 00 sync, 01 black, 10 white |
| disp_active | output | 1 | High during visible picture pixels |
| load_stb | output | 1 | Marks the cycle in which the shift register captures rd_data |

## Verification
The bench sweeps every clock of two full frames of a reduced raster, then resets in the middle of a frame and sweeps one more frame. Each cycle it compares against counts computed from the requirements.

The corner cases it targets are these:
- The first and last pixel of each active line. An off-by-one fetch lead would shift the whole picture by one pixel or lose its last column.
- The bit order inside each byte. A reversed shift would mirror every 8-pixel group.
- The inverted sync on vertical-sync lines. A design that ignores it would show no vertical sync pulse.
- The line-to-line address step and the return to the frame base after the last line and after a reset. If either were wrong, the picture would roll or wander through memory.

// File: rtl/mvid_pkg.sv
package mvid_pkg;
  typedef enum logic [1:0] {
    LVL_SYNC  = 2'b00,
    LVL_BLACK = 2'b01,
    LVL_WHITE = 2'b10
  } level_e;

  localparam int PIX_PER_BYTE = 8;
  localparam int FETCH_LEAD   = 2;
endpackage

// File: rtl/mvid_raster.sv
module mvid_raster #(
  parameter int H_TOTAL = 400,
  parameter int V_TOTAL = 312,
  parameter int HW      = 9,
  parameter int VW      = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [HW-1:0] hcnt,
  output logic [VW-1:0] vcnt,
  output logic          line_end,
  output logic          frame_end
);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);

  logic [HW-1:0] h_nxt;
  logic [VW-1:0] v_nxt;
  logic          v_en;

  always_comb begin
    line_end  = (hcnt == H_LAST);
    frame_end = line_end && (vcnt == V_LAST);
    h_nxt     = line_end ? '0 : hcnt + 1'b1;
    v_en      = line_end;
    v_nxt     = (vcnt == V_LAST) ? '0 : vcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
    end else begin
      hcnt <= h_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcnt <= '0;
    end else if (v_en) begin
      vcnt <= v_nxt;
    end
  end

  // R2: the line wraps after its last count
  a_r2_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt == H_LAST) |=> (hcnt == '0));
  // R5: the line count stays inside the frame
  a_r5_line_range: assert property (@(posedge clk) disable iff (!rst_n)
    vcnt <= V_LAST);
  // R5: the line count holds between line ends
  a_r5_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt != H_LAST) |=> $stable(vcnt));
endmodule

// File: rtl/mvid_fetch.sv
module mvid_fetch
  import mvid_pkg::*;
#(
  parameter int H_ACT_START = 40,
  parameter int H_ACT_END   = 360,
  parameter int V_ACT_START = 60,
  parameter int V_ACT_LINES = 192,
  parameter int HW          = 9,
  parameter int VW          = 9,
  parameter int AW          = 16,
  parameter int FRAME_BASE  = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] hcnt,
  input  logic [VW-1:0] vcnt,
  input  logic          line_end,
  input  logic          frame_end,
  output logic          v_act,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr
);
  localparam int BPL = (H_ACT_END - H_ACT_START) / PIX_PER_BYTE;
  localparam int CW  = $clog2(BPL + 1);
  localparam logic [HW-1:0] FETCH_FIRST = HW'(H_ACT_START - FETCH_LEAD);
  localparam logic [HW-1:0] FETCH_LAST  = HW'(H_ACT_END - PIX_PER_BYTE - FETCH_LEAD);
  localparam logic [VW-1:0] V_FIRST     = VW'(V_ACT_START);
  localparam logic [VW-1:0] V_STOP      = VW'(V_ACT_START + V_ACT_LINES);
  localparam logic [AW-1:0] BASE_RST    = AW'(FRAME_BASE);
  localparam logic [AW-1:0] STEP        = AW'(BPL);
  localparam logic [CW-1:0] COL_MAX     = CW'(BPL);

  logic [AW-1:0] base_q, base_nxt;
  logic [CW-1:0] col_q, col_nxt;
  logic          base_en, col_en;
  logic [HW-1:0] phase;

  always_comb begin
    v_act    = (vcnt >= V_FIRST) && (vcnt < V_STOP);
    phase    = hcnt - FETCH_FIRST;
    rd_en    = v_act && (hcnt >= FETCH_FIRST) && (hcnt <= FETCH_LAST) &&
               (phase[2:0] == 3'd0);
    rd_addr  = base_q + AW'(col_q);
    base_en  = frame_end || (line_end && v_act);
    base_nxt = frame_end ? BASE_RST : base_q + STEP;
    col_en   = line_end || rd_en;
    col_nxt  = line_end ? '0 : col_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= BASE_RST;
    end else if (base_en) begin
      base_q <= base_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
    end else if (col_en) begin
      col_q <= col_nxt;
    end
  end

  // R8: fetches are never on adjacent cycles
  a_r8_fetch_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en);
  // R8: no more fetches per line than the line holds
  a_r8_col_bound: assert property (@(posedge clk) disable iff (!rst_n)
    col_q <= COL_MAX);
  // R11: the address restarts at the frame base after the last line
  a_r11_base_restart: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (rd_addr == BASE_RST));
endmodule

// File: rtl/mvid_shifter.sv
module mvid_shifter
  import mvid_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_en,
  input  logic [7:0] rd_data,
  output logic       load_stb,
  output logic       pix_bit
);
  logic [PIX_PER_BYTE-1:0] sreg_q, sreg_nxt;

  always_comb begin
    sreg_nxt = load_stb ? rd_data : {sreg_q[PIX_PER_BYTE-2:0], 1'b0};
    pix_bit  = sreg_q[PIX_PER_BYTE-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_stb <= 1'b0;
      sreg_q   <= '0;
    end else begin
      load_stb <= rd_en;
      sreg_q   <= sreg_nxt;
    end
  end

  // R10: the most significant bit of the captured byte appears first
  a_r10_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> (pix_bit == $past(rd_data[7])));
  // R9: a load never repeats on the following cycle
  a_r9_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> !load_stb);
endmodule

// File: rtl/mono_video_gen.sv
module mono_video_gen
  import mvid_pkg::*;
#(
  parameter int H_TOTAL     = 400,
  parameter int H_ACT_START = 40,
  parameter int H_ACT_END   = 360,
  parameter int HSYNC_W     = 30,
  parameter int V_TOTAL     = 312,
  parameter int V_ACT_START = 60,
  parameter int V_ACT_LINES = 192,
  parameter int VSYNC_LINES = 3,
  parameter int AW          = 16,
  parameter int FRAME_BASE  = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          rd_en,
  output logic [1:0]    vid_level,
  output logic          disp_active,
  output logic          load_stb
);
  localparam int HW = $clog2(H_TOTAL);
  localparam int VW = $clog2(V_TOTAL);
  localparam logic [HW-1:0] HS_END = HW'(HSYNC_W);
  localparam logic [HW-1:0] HA_LO  = HW'(H_ACT_START);
  localparam logic [HW-1:0] HA_HI  = HW'(H_ACT_END);
  localparam logic [VW-1:0] VS_END = VW'(VSYNC_LINES);

  logic          rs1_q, rs2_q;
  logic          rst_int_n;
  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic          line_end, frame_end, v_act, pix_bit;
  logic          hsync, vsync, h_win;
  level_e        lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_int_n = rs2_q;

  mvid_raster #(
    .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .HW(HW), .VW(VW)
  ) u_raster (
    .clk(clk), .rst_n(rst_int_n), .hcnt(hcnt), .vcnt(vcnt),
    .line_end(line_end), .frame_end(frame_end)
  );

  mvid_fetch #(
    .H_ACT_START(H_ACT_START), .H_ACT_END(H_ACT_END),
    .V_ACT_START(V_ACT_START), .V_ACT_LINES(V_ACT_LINES),
    .HW(HW), .VW(VW), .AW(AW), .FRAME_BASE(FRAME_BASE)
  ) u_fetch (
    .clk(clk), .rst_n(rst_int_n), .hcnt(hcnt), .vcnt(vcnt),
    .line_end(line_end), .frame_end(frame_end), .v_act(v_act),
    .rd_en(rd_en), .rd_addr(rd_addr)
  );

  mvid_shifter u_shift (
    .clk(clk), .rst_n(rst_int_n), .rd_en(rd_en), .rd_data(rd_data),
    .load_stb(load_stb), .pix_bit(pix_bit)
  );

  always_comb begin
    hsync       = (hcnt < HS_END);
    vsync       = (vcnt < VS_END);
    h_win       = (hcnt >= HA_LO) && (hcnt < HA_HI);
    disp_active = h_win && v_act;
    if (hsync ^ vsync)    lvl = LVL_SYNC;
    else if (disp_active) lvl = pix_bit ? LVL_WHITE : LVL_BLACK;
    else                  lvl = LVL_BLACK;
    vid_level   = lvl;
  end

  // R6: the visible window never carries sync
  a_r6_active_no_sync: assert property (@(posedge clk) disable iff (!rst_int_n)
    disp_active |-> (vid_level != 2'b00));
  // R10: the unused level code never appears
  a_r10_legal_level: assert property (@(posedge clk) disable iff (!rst_int_n)
    vid_level != 2'b11);
  // R9: a load is always seen inside the active line band
  a_r9_load_in_band: assert property (@(posedge clk) disable iff (!rst_int_n)
    load_stb |-> v_act);
endmodule

// File: tb/mono_video_gen_tb.sv
`timescale 1ns/1ps
module mono_video_gen_tb;
  localparam int HT = 64, HA0 = 8, HA1 = 40, SW = 4;
  localparam int VT = 20, VA0 = 5, VAL = 6, VSL = 2;
  localparam int FB = 256, BPL = (HA1 - HA0) / 8;
  localparam int FRAME = HT * VT;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  rd_data = 8'h00;
  logic [15:0] rd_addr;
  logic        rd_en, disp_active, load_stb;
  logic [1:0]  vid_level;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mono_video_gen #(
    .H_TOTAL(HT), .H_ACT_START(HA0), .H_ACT_END(HA1), .HSYNC_W(SW),
    .V_TOTAL(VT), .V_ACT_START(VA0), .V_ACT_LINES(VAL), .VSYNC_LINES(VSL),
    .AW(16), .FRAME_BASE(FB)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .rd_addr(rd_addr),
    .rd_en(rd_en), .vid_level(vid_level), .disp_active(disp_active),
    .load_stb(load_stb)
  );

  function automatic logic [7:0] mem_f(int a);
    int t;
    t = (a * 29 + (a >> 3)) ^ 8'h5A;
    return t[7:0];
  endfunction

  always @(posedge clk) if (rd_en) rd_data <= mem_f(int'(rd_addr));

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic chk_reset_state();
    chk("R1", "rd_en", int'(rd_en), 0);
    chk("R1", "load_stb", int'(load_stb), 0);
    chk("R1", "disp_active", int'(disp_active), 0);
    chk("R1", "vid_level", int'(vid_level), 1);
  endtask

  task automatic check_cycle(int n);
    int h, line, v, fr, k, j, lv, exp_lvl, exp_rd, exp_ld;
    bit vs, hs, act;
    string tag;
    logic [7:0] b;
    h = n % HT; line = n / HT; v = line % VT; fr = line / VT;
    vs = (v < VSL); hs = (h < SW);
    act = (h >= HA0) && (h < HA1) && (v >= VA0) && (v < VA0 + VAL);
    if (hs ^ vs) exp_lvl = 0;
    else if (act) begin
      k = (h - HA0) / 8; j = (h - HA0) % 8;
      b = mem_f(FB + (v - VA0) * BPL + k);
      exp_lvl = b[7 - j] ? 2 : 1;
    end else exp_lvl = 1;
    if (vs) tag = (fr > 0) ? "R5" : "R4";
    else if (h == 0) tag = "R2";
    else if (hs) tag = "R3";
    else if (act) tag = "R10";
    else tag = "R7";
    chk(tag, "vid_level", int'(vid_level), exp_lvl);
    chk("R6", "disp_active", int'(disp_active), int'(act));
    lv = v - VA0;
    exp_rd = (v >= VA0 && v < VA0 + VAL && h >= HA0 - 2 && h <= HA1 - 10 &&
              ((h - (HA0 - 2)) % 8) == 0) ? 1 : 0;
    exp_ld = (v >= VA0 && v < VA0 + VAL && h >= HA0 - 1 && h <= HA1 - 9 &&
              ((h - (HA0 - 1)) % 8) == 0) ? 1 : 0;
    chk("R8", "rd_en", int'(rd_en), exp_rd);
    if (exp_rd == 1 && rd_en) begin
      if (lv == 0 && h == HA0 - 2) tag = "R11";
      else tag = "R8";
      chk(tag, "rd_addr", int'(rd_addr), FB + lv * BPL + (h - (HA0 - 2)) / 8);
    end
    chk("R9", "load_stb", int'(load_stb), exp_ld);
  endtask

  task automatic sweep(int cycles);
    for (int n = 0; n < cycles; n++) begin
      @(negedge clk);
      check_cycle(n);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_reset_state();
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    sweep(2 * FRAME + 100);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk_reset_state();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    sweep(FRAME + 10);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule